// File: doc/BRIEF.md
# LCD Panel Controller Register Bank

This block is the software-visible configuration and status store of a small LCD controller. A processor reaches it through a plain 32-bit register bus with a select, a write flag, a byte address and write data. Read data is combinational and comes back in the same cycle as the select. Besides holding the configuration words, the bank decodes the fields that the frame engine needs: enable, palette-loading mode, TFT and monochrome flags, panel width and height, and the subpanel word. It drives them out as plain level pins.

The frame engine reports progress with single-cycle pulses. One pulse marks that a frame is finished, one that the palette is loaded, and one that a synchronisation error occurred. Each pulse sets a sticky status flag. The flags are combined with a two-bit mask into one level interrupt, and the sync-error flag bypasses the mask. Software turning the controller off or on clears and sets these flags as described below. A redraw-request level tells the frame engine that the whole picture must be repainted.

The bank has no back-pressure. Every bus access completes in the cycle it is presented, so there is no valid/ready pair. Each event pulse is taken in the cycle it is high.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset all stored fields and status flags are zero, irq and bus_err are low, redraw_req is high, and panel_width and panel_height read 1. A control read returns 0xfe000c34, a timing0 read returns 0x0000000f, and a timing2 read returns 0xfc000000.
- R2: A write at offset 0x00 stores enable (bit 0), mono (bit 1), interrupt mask (bits 4:3), TFT (bit 7) and palette mode (bits 21:20), and keeps `wdata & 0x01cff300`. A read ORs together: TFT at bit 23, palette mode at bits 21:20, TFT at bit 7, mask at bits 4:3, mono at bit 1, enable at bit 0, the kept bits and 0xfe000c34. The panel_* control pins show the stored fields from the next cycle.
- R3: A write at 0x04 (timing0) stores the whole word. Bits 9:0 hold width minus one, panel_width is that field plus one, and a read returns the stored word ORed with 0x0000000f. A write at 0x08 (timing1) stores the whole word, bits 9:0 hold height minus one, panel_height is that field plus one, and a read returns the stored word unchanged.
- R4: A write at 0x0c (timing2) stores the word, and a read returns it ORed with 0xfc000000.
- R5: A write at 0x14 keeps `wdata & 0xa1ffffff`. Reads and panel_subpanel return the kept value.
- R6: Offset 0x10 is a read-only status word: frame-done at bit 0, sync-error at bit 2, palette-done at bit 6, all other bits zero. A write there changes no state.
- R7: A high ev_frame_done, ev_palette_done or ev_sync_err sets its flag at the next edge. The flag stays set until an enable transition or reset clears it.
- R8: irq is high when frame-done and mask bit 0 are both set, or palette-done and mask bit 1 are both set, or sync-error is set regardless of the mask. It is low otherwise.
- R9: A control write that turns enable from 1 to 0 clears sync-error and, unless the newly written palette mode is 1, sets frame-done. This overrides an event pulse in the same cycle.
- R10: A control write that turns enable from 0 to 1 clears frame-done and palette-done. This overrides event pulses in the same cycle.
- R11: A selected access to any address other than 0x00, 0x04, 0x08, 0x0c, 0x10 or 0x14 reads as zero and changes no state. bus_err is high for exactly the following cycle.
- R12: redraw_req is set by reset and by any write to timing0 or timing1. Otherwise a redraw_done pulse clears it at the next edge, and a timing write wins over redraw_done in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_wr is low |
| bus_err | output | 1 | One-cycle strobe after an access to an undefined offset |
| ev_frame_done | input | 1 | Frame finished pulse |
| ev_palette_done | input | 1 | Palette loaded pulse |
| ev_sync_err | input | 1 | Synchronisation error pulse |
| redraw_done | input | 1 | Frame engine has repainted the full picture |
| panel_en | output | 1 | Controller enable |
| panel_mono | output | 1 | Monochrome panel |
| panel_tft | output | 1 | Active-matrix panel |
| panel_plm | output | 2 | Palette-loading mode |
| panel_width | output | DIM_W+1 | Panel width in pixels |
| panel_height | output | DIM_W+1 | Panel height in lines |
| panel_subpanel | output | 32 | Subpanel configuration word |
| redraw_req | output | 1 | Full repaint required |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that rst_n is released synchronously. They assume bus_wr is only meaningful while bus_sel is high, and that event pulses may arrive in any cycle, including together with a control write. The override rules of R9 and R10 are therefore checked as properties, not excluded. The stimulus keeps to these rules: random accesses hit every defined offset and a spread of undefined and unaligned ones, and random event and redraw pulses often coincide with enable toggles. Directed sequences cover disable with palette mode 1 and a masked sync error.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;
  localparam int unsigned OFF_CTRL   = 'h00;
  localparam int unsigned OFF_TIM0   = 'h04;
  localparam int unsigned OFF_TIM1   = 'h08;
  localparam int unsigned OFF_TIM2   = 'h0c;
  localparam int unsigned OFF_STAT   = 'h10;
  localparam int unsigned OFF_SUB    = 'h14;

  localparam logic [31:0] CTRL_KEEP_MASK = 32'h01cf_f300;
  localparam logic [31:0] CTRL_RD_ONES   = 32'hfe00_0c34;
  localparam logic [31:0] TIM0_RD_ONES   = 32'h0000_000f;
  localparam logic [31:0] TIM2_RD_ONES   = 32'hfc00_0000;
  localparam logic [31:0] SUB_KEEP_MASK  = 32'ha1ff_ffff;

  localparam logic [1:0]  PLM_NO_FRAME_MARK = 2'd1;

  typedef struct packed {
    logic       en;
    logic       mono;
    logic       tft;
    logic [1:0] plm;
    logic [1:0] imask;
  } ctrl_fields_t;
endpackage

// File: rtl/lcdc_cfg_regs.sv
module lcdc_cfg_regs
  import lcdc_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_ctrl,
  input  logic                we_tim0,
  input  logic                we_tim1,
  input  logic                we_tim2,
  input  logic                we_sub,
  input  logic [31:0]         wdata,
  output ctrl_fields_t        fields,
  output logic [31:0]         ctrl_keep,
  output logic [31:0]         tim0,
  output logic [31:0]         tim1,
  output logic [31:0]         tim2,
  output logic [31:0]         sub,
  output logic                en_rise,
  output logic                en_fall,
  output logic [1:0]          plm_new
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields    <= '0;
      ctrl_keep <= '0;
      tim0      <= '0;
      tim1      <= '0;
      tim2      <= '0;
      sub       <= '0;
    end else begin
      if (we_ctrl) begin
        fields.en    <= wdata[0];
        fields.mono  <= wdata[1];
        fields.imask <= wdata[4:3];
        fields.tft   <= wdata[7];
        fields.plm   <= wdata[21:20];
        ctrl_keep    <= wdata & CTRL_KEEP_MASK;
      end
      if (we_tim0) tim0 <= wdata;
      if (we_tim1) tim1 <= wdata;
      if (we_tim2) tim2 <= wdata;
      if (we_sub)  sub  <= wdata & SUB_KEEP_MASK;
    end
  end

  always_comb begin
    en_rise = we_ctrl &  wdata[0] & ~fields.en;
    en_fall = we_ctrl & ~wdata[0] &  fields.en;
    plm_new = wdata[21:20];
  end

  // R2: a control write is reflected in the enable field on the next edge
  assert_ctrl_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_ctrl |=> (fields.en == $past(wdata[0])));
endmodule

// File: rtl/lcdc_status_flags.sv
module lcdc_status_flags
  import lcdc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_frame,
  input  logic       ev_pal,
  input  logic       ev_sync,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic [1:0] plm_new,
  output logic       frame_done,
  output logic       pal_done,
  output logic       sync_err
);
  logic fd_n, pd_n, se_n;

  always_comb begin
    fd_n = frame_done | ev_frame;
    pd_n = pal_done   | ev_pal;
    se_n = sync_err   | ev_sync;
    if (en_fall) begin
      se_n = 1'b0;
      if (plm_new != PLM_NO_FRAME_MARK) fd_n = 1'b1;
    end
    if (en_rise) begin
      fd_n = 1'b0;
      pd_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_done <= 1'b0;
      pal_done   <= 1'b0;
      sync_err   <= 1'b0;
    end else begin
      frame_done <= fd_n;
      pal_done   <= pd_n;
      sync_err   <= se_n;
    end
  end

  assert_sticky_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame && !en_rise) |=> frame_done);
  assert_sticky_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sync && !en_fall) |=> sync_err);
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> !sync_err);
  assert_enable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> (!frame_done && !pal_done));
endmodule

// File: rtl/lcdc_irq_combine.sv
module lcdc_irq_combine (
  input  logic       frame_done,
  input  logic       pal_done,
  input  logic       sync_err,
  input  logic [1:0] imask,
  output logic       irq
);
  always_comb begin
    irq = (frame_done & imask[0]) | (pal_done & imask[1]) | sync_err;
  end
endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic              ev_frame_done,
  input  logic              ev_palette_done,
  input  logic              ev_sync_err,
  input  logic              redraw_done,
  output logic              panel_en,
  output logic              panel_mono,
  output logic              panel_tft,
  output logic [1:0]        panel_plm,
  output logic [DIM_W:0]    panel_width,
  output logic [DIM_W:0]    panel_height,
  output logic [31:0]       panel_subpanel,
  output logic              redraw_req,
  output logic              irq
);
  localparam int NREG = 6;

  logic [NREG-1:0] hit;
  logic            any_hit;
  logic            wr_acc;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign hit[i] = bus_sel && (bus_addr == ADDR_W'(4 * i));
    end
  endgenerate

  assign any_hit = |hit;
  assign wr_acc  = bus_sel & bus_wr;

  ctrl_fields_t fields;
  logic [31:0]  ctrl_keep, tim0, tim1, tim2, sub;
  logic         en_rise, en_fall;
  logic [1:0]   plm_new;
  logic         fd, pd, se;

  lcdc_cfg_regs #(.DIM_W(DIM_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_ctrl  (bus_wr & hit[OFF_CTRL/4]),
    .we_tim0  (bus_wr & hit[OFF_TIM0/4]),
    .we_tim1  (bus_wr & hit[OFF_TIM1/4]),
    .we_tim2  (bus_wr & hit[OFF_TIM2/4]),
    .we_sub   (bus_wr & hit[OFF_SUB/4]),
    .wdata    (bus_wdata),
    .fields   (fields),
    .ctrl_keep(ctrl_keep),
    .tim0     (tim0),
    .tim1     (tim1),
    .tim2     (tim2),
    .sub      (sub),
    .en_rise  (en_rise),
    .en_fall  (en_fall),
    .plm_new  (plm_new)
  );

  lcdc_status_flags u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_frame  (ev_frame_done),
    .ev_pal    (ev_palette_done),
    .ev_sync   (ev_sync_err),
    .en_rise   (en_rise),
    .en_fall   (en_fall),
    .plm_new   (plm_new),
    .frame_done(fd),
    .pal_done  (pd),
    .sync_err  (se)
  );

  lcdc_irq_combine u_irq (
    .frame_done(fd),
    .pal_done  (pd),
    .sync_err  (se),
    .imask     (fields.imask),
    .irq       (irq)
  );

  logic [31:0] ctrl_rd, stat_rd;

  always_comb begin
    ctrl_rd = CTRL_RD_ONES | ctrl_keep
            | (32'(fields.tft) << 23) | (32'(fields.plm) << 20)
            | (32'(fields.tft) << 7)  | (32'(fields.imask) << 3)
            | (32'(fields.mono) << 1) | 32'(fields.en);
    stat_rd = (32'(pd) << 6) | (32'(se) << 2) | 32'(fd);
    bus_rdata = '0;
    if (!bus_wr) begin
      if (hit[OFF_CTRL/4]) bus_rdata = ctrl_rd;
      if (hit[OFF_TIM0/4]) bus_rdata = tim0 | TIM0_RD_ONES;
      if (hit[OFF_TIM1/4]) bus_rdata = tim1;
      if (hit[OFF_TIM2/4]) bus_rdata = tim2 | TIM2_RD_ONES;
      if (hit[OFF_STAT/4]) bus_rdata = stat_rd;
      if (hit[OFF_SUB/4])  bus_rdata = sub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_err    <= 1'b0;
      redraw_req <= 1'b1;
    end else begin
      bus_err <= bus_sel & ~any_hit;
      if (wr_acc & (hit[OFF_TIM0/4] | hit[OFF_TIM1/4])) redraw_req <= 1'b1;
      else if (redraw_done)                            redraw_req <= 1'b0;
    end
  end

  assign panel_en       = fields.en;
  assign panel_mono     = fields.mono;
  assign panel_tft      = fields.tft;
  assign panel_plm      = fields.plm;
  assign panel_width    = {1'b0, tim0[DIM_W-1:0]} + 1'b1;
  assign panel_height   = {1'b0, tim1[DIM_W-1:0]} + 1'b1;
  assign panel_subpanel = sub;

  assert_sync_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    se |-> irq);
  assert_status_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && hit[OFF_STAT/4] && !ev_frame_done && !ev_palette_done && !ev_sync_err)
      |=> $stable({fd, pd, se}));
  assert_err_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !any_hit) |=> bus_err);
  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel && !any_hit));
  assert_redraw_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && hit[OFF_TIM1/4]) |=> redraw_req);
endmodule

// File: tb/lcdc_regbank_test.sv
`timescale 1ns/1ps
module lcdc_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        evf = 1'b0, evp = 1'b0, evs = 1'b0, rdone = 1'b0;
  logic        p_en, p_mono, p_tft;
  logic [1:0]  p_plm;
  logic [10:0] p_w, p_h;
  logic [31:0] p_sub;
  logic        rreq, irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  lcdc_regbank #(.ADDR_W(8), .DIM_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .bus_err(err),
    .ev_frame_done(evf), .ev_palette_done(evp), .ev_sync_err(evs),
    .redraw_done(rdone), .panel_en(p_en), .panel_mono(p_mono), .panel_tft(p_tft),
    .panel_plm(p_plm), .panel_width(p_w), .panel_height(p_h),
    .panel_subpanel(p_sub), .redraw_req(rreq), .irq(irq)
  );

  // reference model state
  logic        m_en, m_mono, m_tft, m_fd, m_pd, m_se, m_inv, m_err;
  logic [1:0]  m_plm, m_msk;
  logic [31:0] m_keep, m_t0, m_t1, m_t2, m_sub;

  task automatic model_reset();
    m_en = 0; m_mono = 0; m_tft = 0; m_fd = 0; m_pd = 0; m_se = 0;
    m_inv = 1; m_err = 0; m_plm = 0; m_msk = 0;
    m_keep = 0; m_t0 = 0; m_t1 = 0; m_t2 = 0; m_sub = 0;
  endtask

  function automatic bit is_def(logic [7:0] a);
    return a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0c || a == 8'h10 || a == 8'h14;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return 32'hfe000c34 | m_keep | (32'(m_tft) << 23) | (32'(m_plm) << 20)
                  | (32'(m_tft) << 7) | (32'(m_msk) << 3) | (32'(m_mono) << 1) | 32'(m_en);
      8'h04: return m_t0 | 32'h0000000f;
      8'h08: return m_t1;
      8'h0c: return m_t2 | 32'hfc000000;
      8'h10: return (32'(m_pd) << 6) | (32'(m_se) << 2) | 32'(m_fd);
      8'h14: return m_sub;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04, 8'h08: return "R3";
      8'h0c: return "R4";
      8'h10: return "R6";
      8'h14: return "R5";
      default: return "R11";
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_fd & m_msk[0]) | (m_pd & m_msk[1]) | m_se;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic fdn, pdn, sen, rise, fall;
    m_err = sel && !is_def(addr);
    fdn = m_fd | evf; pdn = m_pd | evp; sen = m_se | evs;
    rise = sel && wr && addr == 8'h00 &&  wdata[0] && !m_en;
    fall = sel && wr && addr == 8'h00 && !wdata[0] &&  m_en;
    if (fall) begin sen = 0; if (wdata[21:20] != 2'd1) fdn = 1; end
    if (rise) begin fdn = 0; pdn = 0; end
    m_fd = fdn; m_pd = pdn; m_se = sen;
    if (sel && wr && (addr == 8'h04 || addr == 8'h08)) m_inv = 1;
    else if (rdone) m_inv = 0;
    if (sel && wr) begin
      case (addr)
        8'h00: begin
          m_en = wdata[0]; m_mono = wdata[1]; m_msk = wdata[4:3];
          m_tft = wdata[7]; m_plm = wdata[21:20]; m_keep = wdata & 32'h01cff300;
        end
        8'h04: m_t0 = wdata;
        8'h08: m_t1 = wdata;
        8'h0c: m_t2 = wdata;
        8'h14: m_sub = wdata & 32'ha1ffffff;
        default: ;
      endcase
    end
  endtask

  // one bus cycle; rtag overrides the tag used for a read check
  task automatic cyc(logic s, logic w, logic [7:0] a, logic [31:0] d,
                     logic f, logic p, logic y, logic r, string rtag = "");
    @(negedge clk);
    sel = s; wr = w; addr = a; wdata = d; evf = f; evp = p; evs = y; rdone = r;
    #1;
    if (s && !w) chk((rtag != "") ? rtag : read_tag(a), rdata, exp_read(a));
    chk("R8 irq", 32'(irq), 32'(exp_irq()));
    chk("R11 bus_err", 32'(err), 32'(m_err));
    chk("R12 redraw_req", 32'(rreq), 32'(m_inv));
    chk("R2 panel ctrl pins", {27'b0, p_en, p_mono, p_tft, p_plm},
        {27'b0, m_en, m_mono, m_tft, m_plm});
    chk("R3 panel_width", 32'(p_w), 32'({1'b0, m_t0[9:0]} + 11'd1));
    chk("R3 panel_height", 32'(p_h), 32'({1'b0, m_t1[9:0]} + 11'd1));
    chk("R5 panel_subpanel", p_sub, m_sub);
    model_step();
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1cd0;
    void'($urandom(seed));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    cyc(1, 0, 8'h00, 0, 0, 0, 0, 0, "R1 ctrl reset");
    cyc(1, 0, 8'h04, 0, 0, 0, 0, 0, "R1 timing0 reset");
    cyc(1, 0, 8'h0c, 0, 0, 0, 0, 0, "R1 timing2 reset");
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0, "R1 status reset");
    // R12: redraw clears
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 1);
    // enable with both mask bits, frame event
    cyc(1, 1, 8'h00, 32'h0000_0019, 0, 0, 0, 0);
    cyc(0, 0, 8'h00, 0, 1, 0, 0, 0);
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0, "R7 frame flag sticky");
    // R6 write to status ignored
    cyc(1, 1, 8'h10, 32'hffff_ffff, 0, 0, 0, 0);
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0, "R6 status write ignored");
    // disable with palette mode 0: frame-done set, sync cleared
    cyc(0, 0, 8'h00, 0, 0, 0, 1, 0);
    cyc(1, 1, 8'h00, 32'h0000_0000, 0, 0, 1, 0);
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0, "R9 disable plm0");
    // enable plm 1 with simultaneous events: R10 clears
    cyc(1, 1, 8'h00, 32'h0010_0001, 1, 1, 0, 0);
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0, "R10 enable clears");
    // masked-off sync error still interrupts
    cyc(0, 0, 8'h00, 0, 0, 0, 1, 0);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0);
    // disable with plm 1: no frame mark
    cyc(1, 1, 8'h00, 32'h0010_0000, 0, 0, 0, 0);
    cyc(1, 0, 8'h10, 0, 0, 0, 0, 0, "R9 disable plm1");
    // R11 undefined write then read of neighbours
    cyc(1, 1, 8'h18, 32'hffff_ffff, 0, 0, 0, 0);
    cyc(1, 0, 8'h02, 0, 0, 0, 0, 0, "R11 unaligned read");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned r;
      logic [7:0]  a;
      logic        s, w;
      r = $urandom % 16;
      s = (r < 14);
      w = (r < 7);
      if (r < 6)        a = 8'(4 * r);
      else if (r == 6 || r == 13)
        a = ($urandom % 4 == 0) ? 8'(($urandom % 23) | 1) : 8'h18 + 8'($urandom % 232);
      else if (r < 13)  a = 8'(4 * (r - 7));
      else              a = 8'h00;
      cyc(s, w, a, $urandom, ($urandom % 8) == 0, ($urandom % 8) == 0,
          ($urandom % 10) == 0, ($urandom % 8) == 0);
    end
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule